// File: doc/BRIEF.md
# Gigabit Fibre Link Auto-Negotiation Controller

This block carries out the configuration handshake that brings up a 1 Gb/s serial fibre link before packet traffic flows. It builds the local 16-bit configuration word and gathers the configuration words delivered by the receive decoder. It then walks a fixed sequence of negotiation states. It tells the transmit encoder, through a two-bit mode output, whether to send configuration words, idles, or normal packet data.

The local word always claims full-duplex 1 Gb/s operation and never half-duplex. Four 16-bit management registers sit behind a plain parallel register bus: control, status, local advertisement and partner ability. State dwell times come from a link timer. The timer length is a control register field multiplied by a unit cycle count, and it is clamped to a ceiling that corresponds to 0.5 s.

Top module: `gbx_autoneg`

## Requirements
- R1: While control bit 12 (negotiation enable) is 0, the mode output is held at data (2) from the cycle after the write, received words have no effect, and status bits 5 and 2 read 0.
- R2: Address 4 (local advertisement) resets to 0x0020. Bit 5 (full duplex) always reads 1 and bit 6 (half duplex) always reads 0. Only bits 8:7 (pause) and 13:12 (remote fault) are writable; all other bits read 0.
- R3: Address 0 (control) holds bit 12 enable (reset 1) and bits 7:0 timer field (reset RESET_FIELD). Address 1 (status) has bit 5 negotiation complete, bit 3 always 1 and bit 2 link up. Unmapped addresses read 0.
- R4: Writing 1 to control bit 9 restarts negotiation. During the restart dwell the mode is configuration (0) and the transmitted word is 0x0000. Bit 9 always reads back 0.
- R5: The link timer period is max(field,1) x UNIT_CYCLES, capped at LIMIT_CYCLES. After a restart write, the local advertisement appears on the transmit word exactly period+2 clock edges after the write edge.
- R6: Three consecutive non-zero received words that are equal when bit 14 is ignored move the controller to acknowledge detection, where the transmit word is the advertisement with bit 14 set. A differing word restarts the count.
- R7: Three consecutive identical received words with bit 14 set latch that word into address 5. After one timer period the mode becomes idle (1).
- R8: In idle detection, the link comes up only after the timer expires and three consecutive idle indications arrive. The mode then becomes data (2) and status reads 0x002C.
- R9: An all-zero received word in acknowledge detection or any later state returns the controller to its start state. The mode becomes configuration, the transmit word becomes 0x0000 and status reads 0x0008.
- R10: Writes to address 5 have no effect. It changes only when an acknowledged partner word is latched, and it resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 16 | Register write data |
| regWrEn | input | 1 | Register write strobe |
| regRdData | output | 16 | Register read data (combinational) |
| rxCfgValid | input | 1 | A received configuration word is present |
| rxCfgWord | input | 16 | Received configuration word |
| rxIdle | input | 1 | An idle was received |
| xmitMode | output | 2 | 0 configuration, 1 idle, 2 data |
| txCfgWord | output | 16 | Configuration word to transmit |

## Verification
The bench builds the block with UNIT_CYCLES=4, LIMIT_CYCLES=40 and RESET_FIELD=2, so every dwell lasts only a handful of cycles. Those values keep a full negotiation short. They also let a timer field of 15 (60 cycles) hit the 40-cycle ceiling, so the clamp is measured alongside a zero field and two small fields. The short periods also allow exact restart-to-advertisement cycle counts and a full pass from restart to link up, with zero-word fallback and disable.

// File: rtl/gbx_autoneg_pkg.sv
package gbx_autoneg_pkg;

  localparam int CFG_W = 16;
  localparam int TFIELD_W = 8;

  // configuration word bits
  localparam int CW_FD  = 5;
  localparam int CW_HD  = 6;
  localparam int CW_ACK = 14;

  // control and status bits
  localparam int CTL_EN      = 12;
  localparam int CTL_RESTART = 9;
  localparam int STS_DONE    = 5;
  localparam int STS_ABLE    = 3;
  localparam int STS_LINK    = 2;

  // register addresses
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_STATUS  = 1;
  localparam int ADDR_ADV     = 4;
  localparam int ADDR_PARTNER = 5;

  typedef enum logic [2:0] {
    ST_ENABLE, ST_RESTART, ST_ABILITY, ST_ACK, ST_COMPLETE, ST_IDLE, ST_LINKOK
  } anState_t;

  typedef enum logic [1:0] {
    XMIT_CONFIG = 2'd0, XMIT_IDLE = 2'd1, XMIT_DATA = 2'd2
  } xmit_t;

  typedef struct packed {
    logic timerStart;
    logic latchPartner;
  } dpStrobe_t;

  typedef struct packed {
    logic anEnable;
    logic restartReq;
    logic abilityMatch;
    logic ackMatch;
    logic zeroWord;
    logic idleMatch;
    logic timerDone;
  } dpFlags_t;

endpackage

// File: rtl/gbx_autoneg_dp.sv
module gbx_autoneg_dp
  import gbx_autoneg_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int UNIT_CYCLES  = 250000,
  parameter int LIMIT_CYCLES = 62500000,
  parameter int RESET_FIELD  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CFG_W-1:0]  regWrData,
  input  logic              regWrEn,
  output logic [CFG_W-1:0]  regRdData,
  input  logic              rxCfgValid,
  input  logic [CFG_W-1:0]  rxCfgWord,
  input  logic              rxIdle,
  input  dpStrobe_t         strobe,
  input  anState_t          anState,
  output logic [CFG_W-1:0]  advWord,
  output dpFlags_t          flags
);

  localparam int TW = $clog2(LIMIT_CYCLES + 1);
  localparam int PW = TW + TFIELD_W;
  localparam logic [CFG_W-1:0] ACK_MASK = CFG_W'(1) << CW_ACK;

  logic                enableReg;
  logic [TFIELD_W-1:0] fieldReg;
  logic [1:0]          advPause;
  logic [1:0]          advFault;
  logic [CFG_W-1:0]    partnerReg;
  logic [CFG_W-1:0]    lastWord;
  logic [1:0]          sameCnt;
  logic [1:0]          ackCnt;
  logic [1:0]          idleCnt;
  logic                zeroPulse;
  logic [TW-1:0]       timerCnt;
  logic [TW-1:0]       periodCycles;
  logic [PW-1:0]       product;
  logic [TFIELD_W-1:0] unitField;
  logic                wrCtl;
  logic                wrAdv;
  logic                unusedWr;

  assign unusedWr = ^regWrData;
  assign wrCtl = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrAdv = regWrEn && (regAddr == ADDR_W'(ADDR_ADV));

  // register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= 1'b1;
      fieldReg  <= TFIELD_W'(RESET_FIELD);
      advPause  <= '0;
      advFault  <= '0;
    end else begin
      if (wrCtl) begin
        enableReg <= regWrData[CTL_EN];
        fieldReg  <= regWrData[TFIELD_W-1:0];
      end
      if (wrAdv) begin
        advPause <= regWrData[8:7];
        advFault <= regWrData[13:12];
      end
    end
  end

  always_comb begin
    advWord        = '0;
    advWord[CW_FD] = 1'b1;
    advWord[8:7]   = advPause;
    advWord[13:12] = advFault;
  end

  // link timer: period = max(field,1) * unit, capped at the limit
  always_comb begin
    unitField = (fieldReg == '0) ? TFIELD_W'(1) : fieldReg;
    product   = PW'(unitField) * PW'(UNIT_CYCLES);
    if (product > PW'(LIMIT_CYCLES)) periodCycles = TW'(LIMIT_CYCLES);
    else                             periodCycles = product[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  timerCnt <= '0;
    else if (strobe.timerStart) timerCnt <= periodCycles;
    else if (timerCnt != '0)    timerCnt <= timerCnt - TW'(1);
  end

  // received word matching
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWord  <= '0;
      sameCnt   <= '0;
      ackCnt    <= '0;
      idleCnt   <= '0;
      zeroPulse <= 1'b0;
    end else begin
      zeroPulse <= 1'b0;
      if (rxCfgValid) begin
        lastWord  <= rxCfgWord;
        zeroPulse <= (rxCfgWord == '0);
        idleCnt   <= '0;
        if ((rxCfgWord & ~ACK_MASK) == (lastWord & ~ACK_MASK))
          sameCnt <= (sameCnt == 2'd3) ? 2'd3 : sameCnt + 2'd1;
        else
          sameCnt <= 2'd1;
        if (rxCfgWord[CW_ACK] && (rxCfgWord == lastWord))
          ackCnt <= (ackCnt == 2'd3) ? 2'd3 : ackCnt + 2'd1;
        else
          ackCnt <= rxCfgWord[CW_ACK] ? 2'd1 : 2'd0;
      end else if (rxIdle) begin
        sameCnt <= '0;
        ackCnt  <= '0;
        idleCnt <= (idleCnt == 2'd3) ? 2'd3 : idleCnt + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    partnerReg <= '0;
    else if (strobe.latchPartner) partnerReg <= lastWord;
  end

  always_comb begin
    flags.anEnable     = enableReg;
    flags.restartReq   = wrCtl && regWrData[CTL_RESTART];
    flags.abilityMatch = (sameCnt == 2'd3) && ((lastWord & ~ACK_MASK) != '0);
    flags.ackMatch     = (ackCnt == 2'd3);
    flags.zeroWord     = zeroPulse;
    flags.idleMatch    = (idleCnt == 2'd3);
    flags.timerDone    = (timerCnt == '0);
  end

  // read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_CTRL): begin
        regRdData[CTL_EN]         = enableReg;
        regRdData[TFIELD_W-1:0]   = fieldReg;
      end
      ADDR_W'(ADDR_STATUS): begin
        regRdData[STS_DONE] = enableReg && (anState == ST_LINKOK);
        regRdData[STS_ABLE] = 1'b1;
        regRdData[STS_LINK] = (anState == ST_LINKOK);
      end
      ADDR_W'(ADDR_ADV):     regRdData = advWord;
      ADDR_W'(ADDR_PARTNER): regRdData = partnerReg;
      default:               regRdData = '0;
    endcase
  end

endmodule

// File: rtl/gbx_autoneg_ctrl.sv
module gbx_autoneg_ctrl
  import gbx_autoneg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpFlags_t         flags,
  input  logic [CFG_W-1:0] advWord,
  output anState_t         anState,
  output dpStrobe_t        strobe,
  output logic [1:0]       xmitMode,
  output logic [CFG_W-1:0] txCfgWord
);

  anState_t nextState;
  logic     lateState;

  assign lateState = (anState == ST_ACK) || (anState == ST_COMPLETE) ||
                     (anState == ST_IDLE) || (anState == ST_LINKOK);

  always_comb begin
    nextState = anState;
    strobe    = '0;
    unique case (anState)
      ST_ENABLE: if (flags.anEnable) begin
        nextState         = ST_RESTART;
        strobe.timerStart = 1'b1;
      end
      ST_RESTART:  if (flags.timerDone) nextState = ST_ABILITY;
      ST_ABILITY:  if (flags.abilityMatch) nextState = ST_ACK;
      ST_ACK: if (flags.ackMatch) begin
        nextState           = ST_COMPLETE;
        strobe.latchPartner = 1'b1;
        strobe.timerStart   = 1'b1;
      end
      ST_COMPLETE: if (flags.timerDone) begin
        nextState         = ST_IDLE;
        strobe.timerStart = 1'b1;
      end
      ST_IDLE: if (flags.timerDone && flags.idleMatch) nextState = ST_LINKOK;
      ST_LINKOK: nextState = ST_LINKOK;
      default:   nextState = ST_ENABLE;
    endcase
    if ((flags.zeroWord && lateState) || !flags.anEnable || flags.restartReq) begin
      nextState = ST_ENABLE;
      strobe    = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) anState <= ST_ENABLE;
    else       anState <= nextState;
  end

  always_comb begin
    txCfgWord = '0;
    xmitMode  = XMIT_CONFIG;
    case (anState)
      ST_ENABLE:   xmitMode = flags.anEnable ? XMIT_CONFIG : XMIT_DATA;
      ST_ABILITY:  txCfgWord = advWord;
      ST_ACK,
      ST_COMPLETE: begin
        txCfgWord         = advWord;
        txCfgWord[CW_ACK] = 1'b1;
      end
      ST_IDLE:     xmitMode = XMIT_IDLE;
      ST_LINKOK:   xmitMode = XMIT_DATA;
      default:     xmitMode = XMIT_CONFIG;
    endcase
  end

endmodule

// File: rtl/gbx_autoneg.sv
module gbx_autoneg
  import gbx_autoneg_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int UNIT_CYCLES  = 250000,
  parameter int LIMIT_CYCLES = 62500000,
  parameter int RESET_FIELD  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWrData,
  input  logic              regWrEn,
  output logic [15:0]       regRdData,
  input  logic              rxCfgValid,
  input  logic [15:0]       rxCfgWord,
  input  logic              rxIdle,
  output logic [1:0]        xmitMode,
  output logic [15:0]       txCfgWord
);

  anState_t         anState;
  dpStrobe_t        strobe;
  dpFlags_t         flags;
  logic [CFG_W-1:0] advWord;

  gbx_autoneg_dp #(
    .ADDR_W(ADDR_W), .UNIT_CYCLES(UNIT_CYCLES),
    .LIMIT_CYCLES(LIMIT_CYCLES), .RESET_FIELD(RESET_FIELD)
  ) dpInst (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .rxCfgValid(rxCfgValid),
    .rxCfgWord(rxCfgWord), .rxIdle(rxIdle), .strobe(strobe),
    .anState(anState), .advWord(advWord), .flags(flags)
  );

  gbx_autoneg_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .flags(flags), .advWord(advWord),
    .anState(anState), .strobe(strobe), .xmitMode(xmitMode),
    .txCfgWord(txCfgWord)
  );

endmodule

// File: rtl/gbx_autoneg_chk.sv
module gbx_autoneg_chk
  import gbx_autoneg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input anState_t          anState,
  input dpFlags_t          flags,
  input dpStrobe_t         strobe,
  input logic [1:0]        xmitMode,
  input logic [ADDR_W-1:0] regAddr,
  input logic [15:0]       regRdData
);

  // R1
  disabled_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flags.anEnable && $past(!flags.anEnable)) |-> xmitMode == XMIT_DATA);

  // R4
  restart_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.restartReq |=> anState == ST_ENABLE);

  // R5
  restart_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anState == ST_ABILITY && $past(anState) == ST_RESTART) |-> $past(flags.timerDone));

  // R6
  ability_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anState == ST_ACK && $past(anState) == ST_ABILITY) |-> $past(flags.abilityMatch));

  // R7
  latch_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchPartner |-> (flags.ackMatch && anState == ST_ACK));

  // R8
  link_via_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anState == ST_LINKOK && $past(anState) != ST_LINKOK) |->
      ($past(anState) == ST_IDLE && $past(flags.idleMatch) && $past(flags.timerDone)));

  // R9
  zero_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags.zeroWord && (anState == ST_ACK || anState == ST_COMPLETE ||
                        anState == ST_IDLE || anState == ST_LINKOK))
      |=> anState == ST_ENABLE);

  // R10
  partner_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_PARTNER) && $past(regAddr) == ADDR_W'(ADDR_PARTNER) &&
     !$past(strobe.latchPartner)) |-> $stable(regRdData));

endmodule

bind gbx_autoneg gbx_autoneg_chk #(.ADDR_W(ADDR_W)) chkInst (
  .clk(clk), .rstN(rstN), .anState(anState), .flags(flags), .strobe(strobe),
  .xmitMode(xmitMode), .regAddr(regAddr), .regRdData(regRdData)
);

// File: tb/gbx_autoneg_test.sv
module gbx_autoneg_test;

  localparam int ADDR_W = 5;
  localparam int UNIT = 4;
  localparam int LIMIT = 40;
  localparam int RFIELD = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic regWrEn = 1'b0;
  logic [15:0] regRdData;
  logic rxCfgValid = 1'b0;
  logic [15:0] rxCfgWord = '0;
  logic rxIdle = 1'b0;
  logic [1:0] xmitMode;
  logic [15:0] txCfgWord;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] adv = 16'h0020;

  always #5 clk = ~clk;

  gbx_autoneg #(.ADDR_W(ADDR_W), .UNIT_CYCLES(UNIT), .LIMIT_CYCLES(LIMIT),
                .RESET_FIELD(RFIELD)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .rxCfgValid(rxCfgValid),
    .rxCfgWord(rxCfgWord), .rxIdle(rxIdle), .xmitMode(xmitMode),
    .txCfgWord(txCfgWord)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic regWrite(int a, logic [15:0] d);
    regAddr = ADDR_W'(a); regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(int a, output logic [15:0] d);
    regAddr = ADDR_W'(a); #1; d = regRdData;
  endtask

  task automatic sendWord(logic [15:0] w);
    rxCfgValid = 1'b1; rxCfgWord = w;
    @(posedge clk); @(negedge clk);
    rxCfgValid = 1'b0;
  endtask

  task automatic sendIdle();
    rxIdle = 1'b1;
    @(posedge clk); @(negedge clk);
    rxIdle = 1'b0;
  endtask

  task automatic waitMode(logic [1:0] m, int limit);
    for (int i = 0; i < limit && xmitMode != m; i++) step(1);
  endtask

  task automatic testReset();
    logic [15:0] d;
    regRead(0, d); check("R3", "reset control", d, 32'h1002);
    regRead(1, d); check("R3", "reset status", d, 32'h0008);
    regRead(2, d); check("R3", "unmapped read", d, 32'h0000);
    regRead(4, d); check("R2", "reset advertisement", d, 32'h0020);
    regRead(5, d); check("R10", "reset partner", d, 32'h0000);
    check("R4", "reset mode", xmitMode, 32'd0);
    check("R4", "reset tx word", txCfgWord, 32'h0000);
  endtask

  task automatic testAdvert();
    logic [15:0] d;
    regWrite(4, 16'hFFFF);
    regRead(4, d); check("R2", "advert all ones", d, 32'h31A0);
    regWrite(4, 16'h0000);
    regRead(4, d); check("R2", "advert all zeros", d, 32'h0020);
  endtask

  task automatic testTimer();
    logic [15:0] d;
    int fields[4] = '{0, 3, 15, 2};
    foreach (fields[k]) begin
      int period = (fields[k] == 0 ? 1 : fields[k]) * UNIT;
      int n = 0;
      if (period > LIMIT) period = LIMIT;
      regWrite(0, 16'h1200 | 16'(fields[k]));
      check("R4", "mode in restart", xmitMode, 32'd0);
      check("R4", "tx word in restart", txCfgWord, 32'h0000);
      regRead(0, d); check("R4", "restart bit self clears", d, 32'h1000 | fields[k]);
      while (((txCfgWord & 16'hBFFF) != adv) && n < 100) begin
        @(posedge clk); @(negedge clk); n++;
      end
      check("R5", "edges to advertisement", n, period + 2);
    end
  endtask

  task automatic testNegotiate();
    logic [15:0] d;
    sendWord(16'h01A0); sendWord(16'h01A0); sendWord(16'h0180);
    step(2);
    check("R6", "broken run keeps ability state", txCfgWord, adv);
    sendWord(16'h0180); sendWord(16'h4180);
    step(1);
    check("R6", "ack bit ignored in ability match", txCfgWord, adv | 16'h4000);
    sendWord(16'h41A0); sendWord(16'h41A0);
    step(1);
    regRead(5, d); check("R7", "partner not latched early", d, 32'h0000);
    regRead(1, d); check("R8", "status while acknowledging", d, 32'h0008);
    sendWord(16'h41A0);
    step(1);
    regRead(5, d); check("R7", "partner latched", d, 32'h41A0);
    waitMode(2'd1, 30);
    check("R7", "idle mode after complete", xmitMode, 32'd1);
    step(20);
    check("R8", "no idles keeps idle mode", xmitMode, 32'd1);
    sendIdle(); sendIdle(); sendIdle();
    waitMode(2'd2, 10);
    check("R8", "data mode at link up", xmitMode, 32'd2);
    regRead(1, d); check("R8", "status at link up", d, 32'h002C);
  endtask

  task automatic testPartnerWrite();
    logic [15:0] d;
    regWrite(5, 16'h1234);
    regRead(5, d); check("R10", "partner write ignored", d, 32'h41A0);
    check("R10", "mode after partner write", xmitMode, 32'd2);
  endtask

  task automatic testZeroWord();
    logic [15:0] d;
    sendWord(16'h0000);
    step(1);
    check("R9", "mode after zero word", xmitMode, 32'd0);
    check("R9", "tx word after zero word", txCfgWord, 32'h0000);
    regRead(1, d); check("R9", "status after zero word", d, 32'h0008);
    step(15);
    check("R9", "renegotiation advertises", txCfgWord, adv);
  endtask

  task automatic testDisable();
    logic [15:0] d;
    regWrite(0, 16'h0002);
    step(1);
    check("R1", "data mode when disabled", xmitMode, 32'd2);
    regRead(1, d); check("R1", "status when disabled", d, 32'h0008);
    sendWord(16'h01A0); sendWord(16'h01A0); sendWord(16'h01A0);
    sendWord(16'h41A0); sendWord(16'h41A0); sendWord(16'h41A0);
    step(3);
    check("R1", "words ignored when disabled", xmitMode, 32'd2);
    check("R1", "tx word when disabled", txCfgWord, 32'h0000);
    regWrite(0, 16'h1002);
    step(1);
    check("R1", "config mode after enable", xmitMode, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (R1..) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    step(2);
    rstN = 1'b1;
    testAdvert();
    testTimer();
    testNegotiate();
    testPartnerWrite();
    testZeroWord();
    testDisable();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule